// File: doc/BRIEF.md
# Endpoint Multi-Packet Transfer Sequencer

This block sits beside one USB endpoint and turns a single per-bank transfer descriptor into a run of USB packets. Firmware writes a total byte count for a bank; the sequencer then works out each packet's length, advances that bank's running byte count as the link side reports finished packets, and raises a completion pulse when the transfer is over. Firmware does nothing between packets.

For IN transfers the sequencer offers packets of `min(remaining, ep_size)` bytes. When the total is a whole number of full packets, it can add one zero-length packet if asked. For OUT transfers the running count starts at zero and grows by each received length. The transfer ends on a short packet or once the total is reached. Single-packet mode makes every bank descriptor cover exactly one packet. Ping-pong mode alternates packets between two banks, and each bank keeps its own descriptor.

Top module: `mps_seq`

## Requirements
- R1: After reset `cur_bank` is 0, no bank is armed, both bank counts are 0 and `xfer_done` is 0.
- R2: A `desc_wr` pulse to bank `desc_bank` arms that bank, loads `desc_total` into it and clears its running count to 0 on the next clock.
- R3: In multi-packet IN mode (`dir_in`=1, `multi_en`=1), `pkt_len` equals min(total − count, `ep_size`) for the current bank, and each accepted `pkt_done` adds that length to the bank's count.
- R4: An IN multi-packet transfer whose total is an exact multiple of `ep_size` completes on its last full packet when `zlp_en`=0. When `zlp_en`=1 it instead offers one more packet with `pkt_len`=0 and completes when that packet is accepted.
- R5: In multi-packet OUT mode (`dir_in`=0), each accepted `pkt_done` adds `rx_len` to the count. The transfer completes when `rx_len` < `ep_size` or when the count reaches the total.
- R6: With `multi_en`=0 (single-packet mode), a bank's transfer completes on its first accepted packet in either direction. Its count then holds the packet length.
- R7: With `pingpong_en`=1, `cur_bank` toggles after every accepted packet. With `pingpong_en`=0, `cur_bank` is 0 from the next clock on.
- R8: `xfer_done` is high for the single cycle after the accepted packet that ends a transfer, and `xfer_done_bank` names that bank. The bank is then disarmed and its count holds until the bank is rewritten.
- R9: A `pkt_done` while the current bank is not armed is ignored: the counts and `cur_bank` stay as they were and `xfer_done` stays low.
- R10: `pkt_len` never exceeds `ep_size`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_size | input | 11 | Maximum packet size of the endpoint, in bytes |
| dir_in | input | 1 | 1 = IN (device to host), 0 = OUT |
| multi_en | input | 1 | 1 = multi-packet mode, 0 = single-packet mode |
| pingpong_en | input | 1 | 1 = alternate between two banks |
| zlp_en | input | 1 | Append a zero-length packet to exact-multiple IN transfers |
| desc_wr | input | 1 | Descriptor write strobe |
| desc_bank | input | 1 | Bank written by `desc_wr` |
| desc_total | input | 16 | Total byte count written by `desc_wr` |
| pkt_done | input | 1 | Link side finished a packet on the current bank |
| rx_len | input | 11 | Length of the received OUT packet |
| cur_bank | output | 1 | Bank that the next packet uses |
| pkt_len | output | 11 | Length of the next IN packet (largest allowed OUT packet) |
| bank_armed | output | 2 | Per-bank armed flags |
| bank0_count | output | 16 | Running byte count of bank 0 |
| bank1_count | output | 16 | Running byte count of bank 1 |
| xfer_done | output | 1 | One-cycle transfer-complete pulse |
| xfer_done_bank | output | 1 | Bank whose transfer completed |

## Verification
The assertions assume that `ep_size` is nonzero and is not changed while a transfer is running. They assume that an OUT `rx_len` never exceeds the current `pkt_len`. They also assume that firmware does not rewrite a bank's descriptor in the same cycle as a packet event on that bank. The directed bench sets the mode inputs only while no packet is being reported and drives OUT lengths no larger than the offered length. It issues each descriptor write and each packet event in separate cycles.

// File: rtl/mps_pkg.sv
package mps_pkg;

    parameter int CNT_W     = 16;
    parameter int SIZE_W    = 11;
    parameter int NUM_BANKS = 2;
    localparam int BANK_W   = $clog2(NUM_BANKS);

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [SIZE_W-1:0] size_t;
    typedef logic [BANK_W-1:0] bank_t;

    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } dir_e;

    // State kept for one bank.
    typedef struct packed {
        cnt_t total;
        cnt_t count;
        logic armed;
        logic zlp_pend;
    } bank_desc_t;

    // Result of one accepted packet on the current bank.
    typedef struct packed {
        cnt_t new_cnt;
        logic finish;
        logic zlp_next;
    } step_t;

    function automatic cnt_t min_cnt(input cnt_t a, input cnt_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic cnt_t widen(input size_t s);
        return cnt_t'(s);
    endfunction

endpackage

// File: rtl/mps_pkt_step.sv
module mps_pkt_step
    import mps_pkg::*;
(
    input  bank_desc_t desc,
    input  size_t      ep_size,
    input  dir_e       dir,
    input  logic       multi_en,
    input  logic       zlp_en,
    input  size_t      rx_len,
    output size_t      pkt_len,
    output step_t      step
);

    cnt_t remaining;
    cnt_t in_len;
    cnt_t amount;
    cnt_t next_cnt;
    logic reached;
    logic full;

    always_comb begin
        remaining = (desc.count >= desc.total) ? '0 : (desc.total - desc.count);
        in_len    = desc.zlp_pend ? '0 : min_cnt(remaining, widen(ep_size));
        pkt_len   = size_t'(in_len);
        amount    = (dir == DIR_IN) ? in_len : widen(rx_len);
        next_cnt  = desc.count + amount;
        reached   = (next_cnt >= desc.total);
        full      = (amount == widen(ep_size));

        step.new_cnt  = next_cnt;
        step.zlp_next = 1'b0;
        step.finish   = 1'b0;

        if (!multi_en) begin
            step.finish = 1'b1;
        end else if (dir == DIR_IN) begin
            if (desc.zlp_pend) begin
                step.finish = 1'b1;
            end else if (reached) begin
                if (zlp_en && full) begin
                    step.zlp_next = 1'b1;
                end else begin
                    step.finish = 1'b1;
                end
            end
        end else begin
            step.finish = (!full) || reached;
        end
    end

endmodule

// File: rtl/mps_bank_reg.sv
module mps_bank_reg
    import mps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  cnt_t       load_total,
    input  logic       apply,
    input  step_t      step,
    output bank_desc_t desc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            desc <= '0;
        end else if (load) begin
            desc.total    <= load_total;
            desc.count    <= '0;
            desc.armed    <= 1'b1;
            desc.zlp_pend <= 1'b0;
        end else if (apply) begin
            desc.count    <= step.new_cnt;
            desc.zlp_pend <= step.zlp_next;
            desc.armed    <= ~step.finish;
        end
    end

endmodule

// File: rtl/mps_seq.sv
module mps_seq
    import mps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SIZE_W-1:0] ep_size,
    input  logic              dir_in,
    input  logic              multi_en,
    input  logic              pingpong_en,
    input  logic              zlp_en,
    input  logic              desc_wr,
    input  logic [BANK_W-1:0] desc_bank,
    input  logic [CNT_W-1:0]  desc_total,
    input  logic              pkt_done,
    input  logic [SIZE_W-1:0] rx_len,
    output logic [BANK_W-1:0] cur_bank,
    output logic [SIZE_W-1:0] pkt_len,
    output logic [NUM_BANKS-1:0] bank_armed,
    output logic [CNT_W-1:0]  bank0_count,
    output logic [CNT_W-1:0]  bank1_count,
    output logic              xfer_done,
    output logic [BANK_W-1:0] xfer_done_bank
);

    bank_desc_t desc_q [NUM_BANKS];
    bank_desc_t cur_desc;
    step_t      cur_step;
    logic       accept;

    assign cur_desc = desc_q[cur_bank];
    assign accept   = pkt_done && cur_desc.armed;

    mps_pkt_step u_step (
        .desc     (cur_desc),
        .ep_size  (ep_size),
        .dir      (dir_e'(dir_in)),
        .multi_en (multi_en),
        .zlp_en   (zlp_en),
        .rx_len   (rx_len),
        .pkt_len  (pkt_len),
        .step     (cur_step)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        mps_bank_reg u_bank (
            .clk        (clk),
            .rst        (rst),
            .load       (desc_wr && (desc_bank == bank_t'(b))),
            .load_total (desc_total),
            .apply      (accept && (cur_bank == bank_t'(b))),
            .step       (cur_step),
            .desc       (desc_q[b])
        );
        assign bank_armed[b] = desc_q[b].armed;
    end

    assign bank0_count = desc_q[0].count;
    assign bank1_count = desc_q[1].count;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_bank <= '0;
        end else if (!pingpong_en) begin
            cur_bank <= '0;
        end else if (accept) begin
            cur_bank <= cur_bank + bank_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_done      <= 1'b0;
            xfer_done_bank <= '0;
        end else begin
            xfer_done      <= accept && cur_step.finish;
            xfer_done_bank <= cur_bank;
        end
    end

endmodule

// File: rtl/mps_seq_chk.sv
module mps_seq_chk
    import mps_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [SIZE_W-1:0] ep_size,
    input logic              pingpong_en,
    input logic              desc_wr,
    input logic              pkt_done,
    input logic [BANK_W-1:0] cur_bank,
    input logic [SIZE_W-1:0] pkt_len,
    input logic [NUM_BANKS-1:0] bank_armed,
    input logic [CNT_W-1:0]  bank0_count,
    input logic [CNT_W-1:0]  bank1_count,
    input logic              xfer_done,
    input logic [BANK_W-1:0] xfer_done_bank
);

    assert_len_bound_R10: assert property (@(posedge clk) disable iff (rst)
        pkt_len <= ep_size);

    assert_done_after_pkt_R8: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> $past(pkt_done));

    assert_done_was_armed_R8: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> (xfer_done_bank ? $past(bank_armed[1]) : $past(bank_armed[0])));

    assert_bank_fixed_R7: assert property (@(posedge clk) disable iff (rst)
        !pingpong_en |=> (cur_bank == '0));

    assert_bank_toggle_R7: assert property (@(posedge clk) disable iff (rst)
        (pingpong_en && pkt_done && bank_armed[cur_bank]) |=> (cur_bank != $past(cur_bank)));

    assert_counts_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!pkt_done && !desc_wr) |=> ($stable(bank0_count) && $stable(bank1_count)));

    assert_idle_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (pkt_done && !bank_armed[cur_bank]) |=> !xfer_done);

endmodule

bind mps_seq mps_seq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .ep_size        (ep_size),
    .pingpong_en    (pingpong_en),
    .desc_wr        (desc_wr),
    .pkt_done       (pkt_done),
    .cur_bank       (cur_bank),
    .pkt_len        (pkt_len),
    .bank_armed     (bank_armed),
    .bank0_count    (bank0_count),
    .bank1_count    (bank1_count),
    .xfer_done      (xfer_done),
    .xfer_done_bank (xfer_done_bank)
);

// File: tb/mps_seq_bench.sv
module mps_seq_bench;
    import mps_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic [SIZE_W-1:0] ep_size;
    logic              dir_in, multi_en, pingpong_en, zlp_en;
    logic              desc_wr;
    logic [BANK_W-1:0] desc_bank;
    logic [CNT_W-1:0]  desc_total;
    logic              pkt_done;
    logic [SIZE_W-1:0] rx_len;
    logic [BANK_W-1:0] cur_bank;
    logic [SIZE_W-1:0] pkt_len;
    logic [NUM_BANKS-1:0] bank_armed;
    logic [CNT_W-1:0]  bank0_count, bank1_count;
    logic              xfer_done;
    logic [BANK_W-1:0] xfer_done_bank;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mps_seq u_mps_seq (
        .clk(clk), .rst(rst), .ep_size(ep_size), .dir_in(dir_in),
        .multi_en(multi_en), .pingpong_en(pingpong_en), .zlp_en(zlp_en),
        .desc_wr(desc_wr), .desc_bank(desc_bank), .desc_total(desc_total),
        .pkt_done(pkt_done), .rx_len(rx_len), .cur_bank(cur_bank),
        .pkt_len(pkt_len), .bank_armed(bank_armed), .bank0_count(bank0_count),
        .bank1_count(bank1_count), .xfer_done(xfer_done),
        .xfer_done_bank(xfer_done_bank)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load(input int bank, input int total);
        desc_wr    = 1'b1;
        desc_bank  = bank_t'(bank);
        desc_total = cnt_t'(total);
        @(posedge clk);
        @(negedge clk);
        desc_wr = 1'b0;
        check("R2 armed after load", int'(bank_armed[bank]), 1);
        check("R2 count cleared", bank ? int'(bank1_count) : int'(bank0_count), 0);
    endtask

    task automatic send(input int len);
        pkt_done = 1'b1;
        rx_len   = size_t'(len);
        @(posedge clk);
        @(negedge clk);
        pkt_done = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 cur_bank", int'(cur_bank), 0);
        check("R1 armed", int'(bank_armed), 0);
        check("R1 count0", int'(bank0_count), 0);
        check("R1 count1", int'(bank1_count), 0);
        check("R1 xfer_done", int'(xfer_done), 0);
    endtask

    task automatic t_in_multi;
        dir_in = 1'b1; multi_en = 1'b1; zlp_en = 1'b0; pingpong_en = 1'b0;
        load(0, 150);
        check("R3 len pkt1", int'(pkt_len), 64);
        send(0);
        check("R3 count pkt1", int'(bank0_count), 64);
        check("R8 no done mid", int'(xfer_done), 0);
        check("R3 len pkt2", int'(pkt_len), 64);
        send(0);
        check("R3 len short", int'(pkt_len), 22);
        send(0);
        check("R3 final count", int'(bank0_count), 150);
        check("R8 done pulse", int'(xfer_done), 1);
        check("R8 done bank", int'(xfer_done_bank), 0);
        check("R8 disarmed", int'(bank_armed[0]), 0);
        @(negedge clk);
        check("R8 pulse one cycle", int'(xfer_done), 0);
        check("R8 count holds", int'(bank0_count), 150);
    endtask

    task automatic t_in_exact(input logic zlp);
        dir_in = 1'b1; multi_en = 1'b1; zlp_en = zlp; pingpong_en = 1'b0;
        load(0, 128);
        send(0);
        send(0);
        check("R4 count after full", int'(bank0_count), 128);
        if (!zlp) begin
            check("R4 done without zlp", int'(xfer_done), 1);
        end else begin
            check("R4 zlp pending no done", int'(xfer_done), 0);
            check("R4 zlp length", int'(pkt_len), 0);
            send(0);
            check("R4 done after zlp", int'(xfer_done), 1);
            check("R4 count after zlp", int'(bank0_count), 128);
        end
    endtask

    task automatic t_out;
        dir_in = 1'b0; multi_en = 1'b1; zlp_en = 1'b0; pingpong_en = 1'b0;
        load(0, 200);
        send(64);
        check("R5 count grows", int'(bank0_count), 64);
        check("R5 no done full", int'(xfer_done), 0);
        send(30);
        check("R5 short count", int'(bank0_count), 94);
        check("R5 short ends", int'(xfer_done), 1);
        load(0, 128);
        send(64);
        check("R5 no done first", int'(xfer_done), 0);
        send(64);
        check("R5 total ends", int'(xfer_done), 1);
        check("R5 total count", int'(bank0_count), 128);
    endtask

    task automatic t_single;
        dir_in = 1'b1; multi_en = 1'b0; zlp_en = 1'b0; pingpong_en = 1'b0;
        load(0, 20);
        check("R6 single in len", int'(pkt_len), 20);
        send(0);
        check("R6 single in done", int'(xfer_done), 1);
        check("R6 single in count", int'(bank0_count), 20);
        dir_in = 1'b0;
        load(0, 300);
        send(64);
        check("R6 single out done", int'(xfer_done), 1);
        check("R6 single out count", int'(bank0_count), 64);
    endtask

    task automatic t_pingpong;
        dir_in = 1'b1; multi_en = 1'b1; zlp_en = 1'b0; pingpong_en = 1'b1;
        load(0, 100);
        load(1, 64);
        check("R7 start bank", int'(cur_bank), 0);
        send(0);
        check("R7 toggle to 1", int'(cur_bank), 1);
        check("R7 bank0 count", int'(bank0_count), 64);
        check("R7 bank1 len", int'(pkt_len), 64);
        send(0);
        check("R8 bank1 done", int'(xfer_done), 1);
        check("R8 bank1 tag", int'(xfer_done_bank), 1);
        check("R7 toggle to 0", int'(cur_bank), 0);
        check("R7 bank0 remainder", int'(pkt_len), 36);
        send(0);
        check("R8 bank0 done", int'(xfer_done), 1);
        check("R8 bank0 tag", int'(xfer_done_bank), 0);
        check("R7 toggle again", int'(cur_bank), 1);
        pingpong_en = 1'b0;
        @(negedge clk);
        check("R7 fixed bank", int'(cur_bank), 0);
    endtask

    task automatic t_idle;
        dir_in = 1'b1; multi_en = 1'b1; pingpong_en = 1'b0;
        send(0);
        check("R9 no done idle", int'(xfer_done), 0);
        check("R9 count0 kept", int'(bank0_count), 100);
        check("R9 count1 kept", int'(bank1_count), 64);
        check("R9 bank kept", int'(cur_bank), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        ep_size = 11'd64; dir_in = 1'b1; multi_en = 1'b1; pingpong_en = 1'b0;
        zlp_en = 1'b0; desc_wr = 1'b0; desc_bank = '0; desc_total = '0;
        pkt_done = 1'b0; rx_len = '0; rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_in_multi();
        t_in_exact(1'b0);
        t_in_exact(1'b1);
        t_out();
        t_single();
        t_pingpong();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule